// File: doc/BRIEF.md
# Encoded Interrupt Level Input Filter

This block takes a 4-bit external interrupt request bus. The bus carries the priority level in inverted binary form. The pins are asynchronous, so the block first passes them through a two-flop synchronizer. It then takes a sample on each sampling tick and accepts a new code only when two samples in a row are equal. The accepted code is decoded into a priority level from 0 to 15.

The block compares the decoded level with a 4-bit interrupt mask and raises a pending flag. While the system is in standby, the peripheral clock is stopped. Sampling then moves to the slow real-time clock tick, and a pending request also raises a wake flag. When the slow clock is absent, nothing is sampled in standby, so no request and no wake-up can be produced there.

The filter is a two-state machine:
- `ST_STABLE`: the accepted code is held.
- `ST_CAND`: one differing sample is held as a candidate.

On a sampling tick the machine moves as follows:
- Stay in `ST_STABLE` when the sample equals the accepted code.
- Go from `ST_STABLE` to `ST_CAND` when the sample differs from the accepted code. The sample becomes the candidate.
- Go from `ST_CAND` to `ST_STABLE` when the sample equals the candidate. The candidate becomes the accepted code.
- Go from `ST_CAND` to `ST_STABLE` when the sample equals the accepted code again. The transient is dropped.
- Stay in `ST_CAND` when the sample is some third value. The sample becomes the new candidate.

Without a tick, the state does not change.

Top module: `irl_level_filter`

## Requirements
- R1: The accepted 4-bit pin code maps to level 15 minus the code. Code 0000 gives level 15, code 0101 gives level 10 and code 1110 gives level 1.
- R2: Code 1111 gives level 0 (no request), and level 0 never asserts pending or wake.
- R3: A new code is accepted only when two consecutive sampling ticks see the same synchronized value. A value seen on a single tick does not change the level.
- R4: Outside standby, a sample is taken on each clock where `pclk_tick_i` is 1, and not on other clocks. With a tick on every clock, a pin change driven just after an edge appears on `level_o` after the fourth following rising edge, and not after the third.
- R5: In standby, samples are taken only on clocks where `rtc_tick_i` is 1 and `rtc_present_i` is 1. `pclk_tick_i` is ignored.
- R6: In standby with `rtc_present_i` at 0, the level never changes and `wake_o` stays 0.
- R7: `pending_o` is 1 exactly when the level is strictly greater than `mask_i`. It is 0 when the level equals the mask.
- R8: `wake_o` is 1 exactly when `pending_o` is 1, `standby_i` is 1 and `rtc_present_i` is 1.
- R9: After reset, `level_o` is 0 and `pending_o` and `wake_o` are 0.
- R10: When consecutive samples keep disagreeing, the level keeps its last accepted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_code_i | input | 4 | Asynchronous inverted level code from the pins |
| pclk_tick_i | input | 1 | Peripheral clock sampling enable |
| rtc_tick_i | input | 1 | Slow real-time clock sampling enable |
| standby_i | input | 1 | System is in standby |
| rtc_present_i | input | 1 | Slow clock is running |
| mask_i | input | 4 | Current interrupt mask level |
| level_o | output | 4 | Filtered priority level |
| pending_o | output | 1 | Level exceeds mask |
| wake_o | output | 1 | Standby wake-up request |

## Verification
The hardest case to reach from the ports is a candidate that is dropped or replaced. There are two ways this happens:
- The sample returns to the accepted code.
- The sample changes to a third value.

Either way, the filter must end up in a state with no visible effect. The bench reaches this by driving codes for exactly one clock with a tick on every clock, so the synchronized value lasts for a single sample. It also drives codes that alternate every clock. In standby, it spaces slow ticks eight clocks apart and checks the level after each pulse, to show that acceptance waits for the second matching slow tick.

// File: rtl/irl_pkg.sv
package irl_pkg;
    typedef enum logic [0:0] {
        ST_STABLE = 1'b0,
        ST_CAND   = 1'b1
    } filt_state_t;
endpackage

// File: rtl/irl_sync.sv
module irl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= INIT;
        else        chain_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= INIT;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irl_tick_sel.sv
module irl_tick_sel (
    input  logic pclk_tick_i,
    input  logic rtc_tick_i,
    input  logic standby_i,
    input  logic rtc_present_i,
    output logic tick_o
);
    always_comb begin
        if (standby_i) tick_o = rtc_tick_i & rtc_present_i;
        else           tick_o = pclk_tick_i;
    end
endmodule

// File: rtl/irl_filter.sv
module irl_filter
    import irl_pkg::*;
#(
    parameter int W = 4,
    localparam logic [W-1:0] IDLE_CODE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] code_i,
    output logic [W-1:0] level_o
);
    filt_state_t  state_q, state_d;
    logic [W-1:0] cand_q, cand_d;
    logic [W-1:0] acc_q, acc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
            cand_q  <= IDLE_CODE;
            acc_q   <= IDLE_CODE;
        end else begin
            state_q <= state_d;
            cand_q  <= cand_d;
            acc_q   <= acc_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        acc_d   = acc_q;
        if (tick_i) begin
            unique case (state_q)
                ST_STABLE: begin
                    if (code_i != acc_q) begin
                        cand_d  = code_i;
                        state_d = ST_CAND;
                    end
                end
                ST_CAND: begin
                    if (code_i == cand_q) begin
                        acc_d   = cand_q;
                        state_d = ST_STABLE;
                    end else if (code_i == acc_q) begin
                        state_d = ST_STABLE;
                    end else begin
                        cand_d  = code_i;
                    end
                end
                default: state_d = ST_STABLE;
            endcase
        end
    end

    always_comb begin
        level_o = IDLE_CODE - acc_q;
    end

    // R3: an accepted code only changes out of the candidate state
    a_r3_accept_from_cand: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q != $past(acc_q)) |-> ($past(state_q) == ST_CAND));

    // R4: without a sampling tick the accepted code stays put
    a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(acc_q));
endmodule

// File: rtl/irl_decide.sv
module irl_decide #(
    parameter int W = 4
) (
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] mask_i,
    input  logic         standby_i,
    input  logic         rtc_present_i,
    output logic         pending_o,
    output logic         wake_o
);
    always_comb begin
        pending_o = (level_i > mask_i);
        wake_o    = pending_o & standby_i & rtc_present_i;
    end
endmodule

// File: rtl/irl_level_filter.sv
module irl_level_filter #(
    parameter int W           = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_code_i,
    input  logic         pclk_tick_i,
    input  logic         rtc_tick_i,
    input  logic         standby_i,
    input  logic         rtc_present_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] level_o,
    output logic         pending_o,
    output logic         wake_o
);
    logic [W-1:0] code_sync;
    logic         tick;

    irl_sync #(.W(W), .STAGES(SYNC_STAGES), .INIT('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_code_i),
        .q_o   (code_sync)
    );

    irl_tick_sel u_tick (
        .pclk_tick_i   (pclk_tick_i),
        .rtc_tick_i    (rtc_tick_i),
        .standby_i     (standby_i),
        .rtc_present_i (rtc_present_i),
        .tick_o        (tick)
    );

    irl_filter #(.W(W)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .code_i  (code_sync),
        .level_o (level_o)
    );

    irl_decide #(.W(W)) u_dec (
        .level_i       (level_o),
        .mask_i        (mask_i),
        .standby_i     (standby_i),
        .rtc_present_i (rtc_present_i),
        .pending_o     (pending_o),
        .wake_o        (wake_o)
    );

    // R6: standby without the slow clock freezes the level
    a_r6_no_rtc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_i && !rtc_present_i) |=> $stable(level_o));

    // R5: in standby only a slow tick may move the level
    a_r5_standby_slow_only: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_i && !rtc_tick_i) |=> $stable(level_o));

    // R2: level zero is never pending and never wakes
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0) |-> (!pending_o && !wake_o));
endmodule

// File: tb/irl_level_filter_test.sv
module irl_level_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_code = 4'hF;
    logic       pclk_tick = 1'b1;
    logic       rtc_tick = 1'b0;
    logic       standby = 1'b0;
    logic       rtc_present = 1'b0;
    logic [3:0] mask = 4'h0;
    logic [3:0] level;
    logic       pending;
    logic       wake;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irl_level_filter uut (
        .clk(clk), .rst_n(rst_n), .req_code_i(req_code),
        .pclk_tick_i(pclk_tick), .rtc_tick_i(rtc_tick),
        .standby_i(standby), .rtc_present_i(rtc_present),
        .mask_i(mask), .level_o(level), .pending_o(pending), .wake_o(wake)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_level(input logic [3:0] c);
        return 15 - int'(c);
    endfunction

    task automatic t_reset();
        chk("R9 level", level, 0);
        chk("R9 pending", pending, 0);
        chk("R9 wake", wake, 0);
    endtask

    task automatic t_decode();
        logic [3:0] codes [4] = '{4'b0000, 4'b0101, 4'b1110, 4'b1111};
        mask = 4'h0;
        foreach (codes[i]) begin
            req_code = codes[i];
            step(6);
            chk(codes[i] == 4'hF ? "R2 level" : "R1 level", level, exp_level(codes[i]));
            chk(codes[i] == 4'hF ? "R2 pending" : "R1 pending", pending, codes[i] != 4'hF);
        end
    endtask

    task automatic t_latency();
        req_code = 4'b1010;
        step(3);
        chk("R4 before fourth edge", level, 0);
        step(1);
        chk("R4 at fourth edge", level, 5);
    endtask

    task automatic t_glitch();
        req_code = 4'b1010; step(6);
        req_code = 4'b0000; step(1);
        req_code = 4'b1010; step(8);
        chk("R3 one-sample glitch", level, 5);
        req_code = 4'b0011; step(1);
        req_code = 4'b0001; step(1);
        req_code = 4'b1010; step(8);
        chk("R3 glitch replaced", level, 5);
    endtask

    task automatic t_alternate();
        req_code = 4'b1100; step(6);
        for (int k = 0; k < 10; k++) begin
            req_code = k[0] ? 4'b0010 : 4'b0100;
            step(1);
        end
        chk("R10 alternating hold", level, 3);
        req_code = 4'b1100; step(6);
    endtask

    task automatic t_no_tick();
        pclk_tick = 1'b0;
        req_code = 4'b0001; step(10);
        chk("R4 no tick", level, 3);
        pclk_tick = 1'b1; step(6);
        chk("R4 tick resumes", level, 14);
    endtask

    task automatic t_mask();
        req_code = 4'b1000; step(6);
        mask = 4'd7; step(0);
        chk("R7 equal mask", pending, 0);
        mask = 4'd6; step(0);
        chk("R7 mask below", pending, 1);
        mask = 4'd8; step(0);
        chk("R7 mask above", pending, 0);
        mask = 4'd6;
    endtask

    task automatic t_standby_no_rtc();
        standby = 1'b1; rtc_present = 1'b0;
        req_code = 4'b0000;
        for (int k = 0; k < 4; k++) begin
            rtc_tick = 1'b1; step(1); rtc_tick = 1'b0; step(7);
        end
        chk("R6 level frozen", level, 7);
        chk("R6 wake", wake, 0);
        chk("R8 pending without wake", pending, 1);
    endtask

    task automatic t_standby_rtc();
        rtc_present = 1'b1; pclk_tick = 1'b1;
        req_code = 4'b1000; step(6);
        req_code = 4'b0011; step(12);
        chk("R5 pclk ignored", level, 7);
        chk("R8 wake", wake, 1);
        rtc_tick = 1'b1; step(1); rtc_tick = 1'b0; step(7);
        chk("R5 one slow tick", level, 7);
        rtc_tick = 1'b1; step(1); rtc_tick = 1'b0; step(7);
        chk("R5 second slow tick", level, 12);
        chk("R8 wake high level", wake, 1);
        mask = 4'd12; step(0);
        chk("R8 wake needs pending", wake, 0);
        standby = 1'b0; mask = 4'd6; step(0);
        chk("R8 no wake outside standby", wake, 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_decode();
        t_latency();
        t_glitch();
        t_alternate();
        t_no_tick();
        t_mask();
        req_code = 4'b1000; step(6);
        t_standby_no_rtc();
        t_standby_rtc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule